// File: doc/BRIEF.md
# Multi-limb modular adder-subtractor

This block adds or subtracts two wide operands modulo a modulus that is loaded at run time. The operands, the modulus and the result are each 264 bits wide. They are held as three 88-bit limbs, least significant limb first. The block computes r = a + s·b mod f, where s is +1 (add) or -1 (subtract). Both operands are assumed to be already reduced, which means they are below f.

The block also reports how the result relates to the unreduced value. It outputs a signed overflow term q and a signed carry or borrow flag for each limb boundary. These outputs make each per-limb relation visible at the ports, so logic further down the chip can check or reuse them.

Operation, one limb per cycle:
- **Accept.** A start strobe seen in the idle state captures a, b, f and the sign. In that same cycle the block compares the full-width a + s·b against f (when adding) or against zero (when subtracting) and registers q.
- **Limb pass.** Each following cycle handles one limb, lowest first. It computes a_i + s·b_i - q·f_i + c_(i-1), writes the low 88 bits into result limb i and keeps the upper part as the carry c_i.

The controller has three states:
- `ST_IDLE` waits for start. The *accept* transition (start high) loads the operands and goes to `ST_RUN`.
- `ST_RUN` steps a limb index. It stays in `ST_RUN` while lower limbs remain. The *finish* transition on the top limb goes to `ST_FIN`.
- `ST_FIN` drives the one-cycle done pulse. It always takes the *release* transition back to `ST_IDLE`.

Top module: `modadd_engine`

## Requirements
- R1: With sub_i = 0, after done the output r_o equals (a + b) mod f. Limb i of r_o occupies bits 88·i to 88·i+87 (little-endian).
- R2: With sub_i = 1, after done the output r_o equals (a - b) mod f, which is a - b + f when a < b.
- R3: q_o is a 2-bit two's-complement value: 2'b00 = 0, 2'b01 = +1, 2'b11 = -1.
  - With sub_i = 0, q is +1 exactly when a + b ≥ f, and 0 otherwise.
  - With sub_i = 1, q is -1 exactly when a < b, and 0 otherwise.
  - q is never of the opposite sign to s, and never 2'b10.
- R4: carry_o[1:0] holds c0 and carry_o[3:2] holds c1. Each is a 2-bit two's-complement value in {-1, 0, +1} (2'b11 = borrow, 2'b01 = carry, never 2'b10). The following limb relations hold:
  - a0 + s·b0 = q·f0 + r0 + c0·2^88
  - a1 + s·b1 = q·f1 + r1 + c1·2^88 - c0
  - a2 + s·b2 = q·f2 + r2 - c1
- R5: The carry out of the top limb is always zero and is not output.
- R6: start_i is sampled on a rising clock edge. done_o is high for exactly one cycle, after the third following rising edge.
- R7: start_i is ignored while a run is in progress, including the done cycle. The result of the run that was accepted is not disturbed, and no extra done pulse appears.
- R8: While rst_n is low, r_o, q_o and carry_o are zero and done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start strobe, used only when idle |
| sub_i | input | 1 | 0 = add, 1 = subtract |
| a_i | input | 264 | Left operand, below f |
| b_i | input | 264 | Right operand, below f |
| f_i | input | 264 | Modulus |
| r_o | output | 264 | Reduced result |
| q_o | output | 2 | Signed overflow term |
| carry_o | output | 4 | Signed limb carries c1 and c0 |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The directed cases target the edges of each behaviour:
- The maximal sum a = b = f-1 must wrap to f-2 with q = +1. A design that compares with > instead of ≥ would leave the sum a + b = f unreduced.
- Subtraction with a = b, and subtraction of f-1 from zero, probe the q = -1 boundary. A wrong q would show up as a result off by f.
- The operand pair a = 2^176, b = 1 forces borrows across both limb boundaries. A carry that is dropped or sign-flipped breaks the limb relations that the bench checks from the outputs.

The random cases use moduli from tiny to near 2^264, with b = 0 and a = b mixed in. A start pulse during a run and in the done cycle exposes a controller that restarts or pulses twice.

// File: rtl/modadd_pkg.sv
package modadd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } phase_t;

    localparam logic [1:0] Q_ZERO  = 2'b00;
    localparam logic [1:0] Q_PLUS  = 2'b01;
    localparam logic [1:0] Q_MINUS = 2'b11;

endpackage

// File: rtl/modadd_qsel.sv
module modadd_qsel
    import modadd_pkg::*;
#(
    parameter int WIDTH = 264
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] f_i,
    input  logic             sub_i,
    output logic [1:0]       q_o
);

    logic [WIDTH:0] wide_sum;

    always_comb begin
        wide_sum = {1'b0, a_i} + {1'b0, b_i};
        if (sub_i) begin
            q_o = (a_i < b_i) ? Q_MINUS : Q_ZERO;
        end else begin
            q_o = (wide_sum >= {1'b0, f_i}) ? Q_PLUS : Q_ZERO;
        end
    end

endmodule

// File: rtl/modadd_limb_slice.sv
module modadd_limb_slice
    import modadd_pkg::*;
#(
    parameter int LIMB_W = 88
) (
    input  logic [LIMB_W-1:0] a_i,
    input  logic [LIMB_W-1:0] b_i,
    input  logic [LIMB_W-1:0] f_i,
    input  logic              sub_i,
    input  logic [1:0]        q_i,
    input  logic [1:0]        cin_i,
    output logic [LIMB_W-1:0] r_o,
    output logic [1:0]        cout_o
);

    localparam int TW = LIMB_W + 2;

    logic [TW-1:0] a_x, b_term, f_term, c_x, total;

    always_comb begin
        a_x    = {2'b00, a_i};
        c_x    = {{LIMB_W{cin_i[1]}}, cin_i};
        b_term = sub_i ? (TW'(0) - {2'b00, b_i}) : {2'b00, b_i};
        unique case (q_i)
            Q_PLUS:  f_term = TW'(0) - {2'b00, f_i};
            Q_MINUS: f_term = {2'b00, f_i};
            default: f_term = '0;
        endcase
        total  = a_x + b_term + f_term + c_x;
        r_o    = total[LIMB_W-1:0];
        cout_o = total[TW-1:LIMB_W];
    end

endmodule

// File: rtl/modadd_ctrl.sv
module modadd_ctrl
    import modadd_pkg::*;
#(
    parameter int NLIMB = 3,
    parameter int IW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          load_o,
    output logic          limb_en_o,
    output logic          last_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [IW-1:0] idx_o
);

    phase_t        state_q, state_d;
    logic [IW-1:0] idx_q;
    logic          at_top;

    assign at_top = (idx_q == IW'(NLIMB - 1));
    assign idx_o  = idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             idx_q <= '0;
        else if (state_q != ST_RUN)             idx_q <= '0;
        else if (!at_top)                       idx_q <= idx_q + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;
            ST_RUN:  if (at_top)  state_d = ST_FIN;
            ST_FIN:               state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_o    = 1'b0;
        limb_en_o = 1'b0;
        last_o    = 1'b0;
        busy_o    = 1'b1;
        done_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
                load_o = start_i;
            end
            ST_RUN: begin
                limb_en_o = 1'b1;
                last_o    = at_top;
            end
            ST_FIN:  done_o = 1'b1;
            default: busy_o = 1'b0;
        endcase
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i) |=> (state_q == ST_RUN && idx_q == '0));

endmodule

// File: rtl/modadd_engine.sv
module modadd_engine
    import modadd_pkg::*;
#(
    parameter int LIMB_W = 88,
    parameter int NLIMB  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic                          sub_i,
    input  logic [LIMB_W*NLIMB-1:0]       a_i,
    input  logic [LIMB_W*NLIMB-1:0]       b_i,
    input  logic [LIMB_W*NLIMB-1:0]       f_i,
    output logic [LIMB_W*NLIMB-1:0]       r_o,
    output logic [1:0]                    q_o,
    output logic [2*(NLIMB-1)-1:0]        carry_o,
    output logic                          done_o
);

    localparam int WIDTH = LIMB_W * NLIMB;
    localparam int CW    = 2 * (NLIMB - 1);
    localparam int IW    = (NLIMB > 1) ? $clog2(NLIMB) : 1;

    logic [WIDTH-1:0]  a_q, b_q, f_q, r_q;
    logic              sub_q;
    logic [1:0]        q_q, q_new, cin_q;
    logic [CW-1:0]     carry_q;

    logic              load, limb_en, last, busy;
    logic [IW-1:0]     idx;
    logic [LIMB_W-1:0] limb_r;
    logic [1:0]        limb_cout;

    modadd_ctrl #(.NLIMB(NLIMB), .IW(IW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .load_o    (load),
        .limb_en_o (limb_en),
        .last_o    (last),
        .busy_o    (busy),
        .done_o    (done_o),
        .idx_o     (idx)
    );

    modadd_qsel #(.WIDTH(WIDTH)) u_qsel (
        .a_i   (a_i),
        .b_i   (b_i),
        .f_i   (f_i),
        .sub_i (sub_i),
        .q_o   (q_new)
    );

    modadd_limb_slice #(.LIMB_W(LIMB_W)) u_slice (
        .a_i    (a_q[idx*LIMB_W +: LIMB_W]),
        .b_i    (b_q[idx*LIMB_W +: LIMB_W]),
        .f_i    (f_q[idx*LIMB_W +: LIMB_W]),
        .sub_i  (sub_q),
        .q_i    (q_q),
        .cin_i  (cin_q),
        .r_o    (limb_r),
        .cout_o (limb_cout)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q     <= '0;
            b_q     <= '0;
            f_q     <= '0;
            sub_q   <= 1'b0;
            q_q     <= Q_ZERO;
            cin_q   <= 2'b00;
            r_q     <= '0;
            carry_q <= '0;
        end else begin
            if (load) begin
                a_q   <= a_i;
                b_q   <= b_i;
                f_q   <= f_i;
                sub_q <= sub_i;
                q_q   <= q_new;
                cin_q <= 2'b00;
            end
            if (limb_en) begin
                r_q[idx*LIMB_W +: LIMB_W] <= limb_r;
                cin_q                     <= limb_cout;
                if (!last) carry_q[idx*2 +: 2] <= limb_cout;
            end
        end
    end

    assign r_o     = r_q;
    assign q_o     = q_q;
    assign carry_o = carry_q;

    // R3
    q_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (q_q != 2'b10) && !(sub_q && q_q == Q_PLUS) && !(!sub_q && q_q == Q_MINUS));

    // R4
    carry_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        limb_en |-> (limb_cout != 2'b10));

    // R5
    top_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (limb_en && last) |-> (limb_cout == 2'b00));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(a_q) && $stable(b_q) && $stable(f_q) && $stable(sub_q) && $stable(q_q)));

endmodule

// File: tb/sim_modadd_engine.sv
`timescale 1ns/1ps
module sim_modadd_engine;

    localparam int LW = 88;
    localparam int NL = 3;
    localparam int W  = LW * NL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          sub_i = 1'b0;
    logic [W-1:0]  a_i = '0, b_i = '0, f_i = '0;
    logic [W-1:0]  r_o;
    logic [1:0]    q_o;
    logic [3:0]    carry_o;
    logic          done_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    modadd_engine #(.LIMB_W(LW), .NLIMB(NL)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sub_i(sub_i),
        .a_i(a_i), .b_i(b_i), .f_i(f_i),
        .r_o(r_o), .q_o(q_o), .carry_o(carry_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] rnd_w();
        logic [W-1:0] v = '0;
        for (int k = 0; k < 9; k++) v = (v << 32) | W'($urandom());
        return v;
    endfunction

    function automatic logic [W-1:0] exp_r(input logic [W-1:0] a, b, f, input bit sub);
        logic [W+1:0] t;
        if (!sub) begin
            t = {2'b00, a} + {2'b00, b};
            if (t >= {2'b00, f}) t = t - {2'b00, f};
        end else begin
            if (a >= b) t = {2'b00, a} - {2'b00, b};
            else        t = {2'b00, a} + {2'b00, f} - {2'b00, b};
        end
        return t[W-1:0];
    endfunction

    function automatic logic [1:0] exp_q(input logic [W-1:0] a, b, f, input bit sub);
        logic [W:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (sub) return (a < b) ? 2'b11 : 2'b00;
        return (s >= {1'b0, f}) ? 2'b01 : 2'b00;
    endfunction

    function automatic logic signed [95:0] sval(input logic [1:0] v);
        case (v)
            2'b01:   return 96'sd1;
            2'b11:   return -96'sd1;
            default: return 96'sd0;
        endcase
    endfunction

    // R4: check the three limb relations from the outputs
    task automatic check_limbs(input logic [W-1:0] a, b, f, input bit sub);
        logic signed [95:0] lhs, rhs, cprev, cnow, qv;
        logic [1:0] craw;
        qv    = sval(q_o);
        cprev = 96'sd0;
        for (int i = 0; i < NL; i++) begin
            if (i < NL - 1) begin
                craw = carry_o[2*i +: 2];
                chk(craw != 2'b10, "R4 carry code", W'(craw), W'(1));
                cnow = sval(craw);
            end else begin
                cnow = 96'sd0;
            end
            lhs = $signed({8'd0, a[i*LW +: LW]});
            if (sub) lhs = lhs - $signed({8'd0, b[i*LW +: LW]});
            else     lhs = lhs + $signed({8'd0, b[i*LW +: LW]});
            rhs = qv * $signed({8'd0, f[i*LW +: LW]}) + $signed({8'd0, r_o[i*LW +: LW]})
                  + (cnow <<< LW) - cprev;
            chk(lhs == rhs, (i == NL - 1) ? "R5 top limb relation" : "R4 limb relation",
                W'(rhs), W'(lhs));
            cprev = cnow;
        end
    endtask

    task automatic run(input logic [W-1:0] a, b, f, input bit sub, input bit disturb);
        int lat;
        logic [W-1:0] er;
        er = exp_r(a, b, f, sub);
        @(negedge clk);
        a_i = a; b_i = b; f_i = f; sub_i = sub; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 40) begin
            if (disturb && lat == 2) begin
                a_i = ~a; b_i = a; sub_i = ~sub; start_i = 1'b1;
            end
            @(negedge clk);
            start_i = 1'b0;
            lat++;
        end
        // R6
        chk(lat == NL + 1, "R6 done latency", W'(lat), W'(NL + 1));
        if (sub) chk(r_o == er, "R2 difference", r_o, er);
        else     chk(r_o == er, "R1 sum", r_o, er);
        chk(q_o == exp_q(a, b, f, sub), "R3 overflow term", W'(q_o), W'(exp_q(a, b, f, sub)));
        check_limbs(a, b, f, sub);
        if (disturb) begin
            a_i = rnd_w(); start_i = 1'b1;
        end
        @(negedge clk);
        start_i = 1'b0;
        // R6
        chk(done_o == 1'b0, "R6 single pulse", W'(done_o), W'(0));
        if (disturb) begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                // R7
                chk(done_o == 1'b0 && r_o == er, "R7 start ignored", r_o, er);
            end
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] f, a, b;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R8
        chk(r_o == '0 && q_o == 2'b00 && carry_o == 4'd0 && done_o == 1'b0,
            "R8 reset state", r_o, '0);
        rst_n = 1'b1;
        @(negedge clk);

        f = rnd_w() | (W'(1) << (W - 1));
        run(f - 1, f - 1, f, 1'b0, 1'b0);              // R1 maximal sum
        run(f - 5, W'(5), f, 1'b0, 1'b0);              // R1 sum equal to f
        run(f - 6, W'(5), f, 1'b0, 1'b0);              // R1 just below f
        run(W'(77), W'(77), f, 1'b1, 1'b0);            // R2 a = b
        run(W'(0), f - 1, f, 1'b1, 1'b0);              // R2 deepest underflow
        run(W'(1) << 176, W'(1), f, 1'b1, 1'b0);       // R4 borrow chain
        run((W'(1) << 176) - 1, W'(1), f, 1'b0, 1'b0); // R4 carry chain
        run(f - 1, W'(0), f, 1'b0, 1'b0);              // R1 b = 0
        run({W{1'b1}} - 1, {W{1'b1}} - 2, {W{1'b1}}, 1'b0, 1'b0);
        run(W'(3), W'(5), W'(7), 1'b1, 1'b0);          // R2 tiny modulus
        run(f - 3, f - 4, f, 1'b0, 1'b1);              // R7 disturbed run

        for (int t = 0; t < 300; t++) begin
            f = rnd_w() >> ($urandom() % 250);
            if (f < 2) f = W'(2);
            a = rnd_w() % f;
            b = rnd_w() % f;
            case ($urandom() % 6)
                0: b = '0;
                1: b = a;
                default: ;
            endcase
            run(a, b, f, bit'($urandom() % 2), (t % 37) == 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule